// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block sits between a host processor and the two device channels of a PS/2-style keyboard controller. The host has two byte-wide write strobes: one for the command/status port and one for the data port. Command bytes are decoded in a single cycle. A command can update an 8-bit mode register or the status flags. It can also post a fixed or state-derived reply byte onto the keyboard-channel output stream. Some commands arm a pending state, and that state decides where the next data-port byte goes.

A data-port write is routed by the pending state. With nothing pending, the byte goes to the keyboard device. Otherwise it can load the mode register, be posted on the keyboard or aux output stream, be sent to the mouse device, or be absorbed. The pending state clears after that one write. All outputs are registered, so every effect of a write appears on the cycle after the strobe. Each device-facing output is a valid pulse with a byte.

Top module: `kbc_host_engine`

## Requirements
- R1: In reset and on the cycle after it, the mode register reads 0x03 and the status register reads 0x18. Nothing is pending, every valid strobe is low, both interrupt enables are high and the translation enable is low.
- R2: Status bit 3 is set by every command-port write, whatever the code. It is cleared by every data-port write that is not paired with a command write.
- R3: Command 0x20 posts the current mode register value on the keyboard reply stream, one cycle after the strobe.
- R4: Command 0xAA sets status bit 2 and posts 0x55. The bit stays set until reset. Commands 0xA9 and 0xAB post 0x00, and command 0xC0 posts 0x80.
- R5: Command 0xA7 sets mode bit 5 and 0xA8 clears it. Command 0xAD sets mode bit 4 and 0xAE clears it. The keyboard interrupt enable equals mode bit 0 AND NOT mode bit 4. The mouse interrupt enable equals mode bit 1.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending state, and a later arming command replaces an earlier one. Any other command leaves the pending state unchanged.
- R7: A data write with nothing pending goes to the keyboard device. The pending state selects the destination as follows:
  - 0xD2: posted on the keyboard reply stream.
  - 0xD3: posted on the aux reply stream.
  - 0xD4: sent to the mouse device.

  Exactly one data write clears the pending state, and at most one device or stream valid strobe fires per cycle.
- R8: With 0x60 pending, a data write loads the mode register. The translation enable output always equals mode bit 6.
- R9: Any command code outside the fourteen listed in R3 to R8 is unknown. It raises bad_cmd for one cycle, posts no reply and leaves the mode, the pending state and status bit 2 unchanged.
- R10: When both strobes are high in the same cycle, only the command is acted on and the data byte is dropped.
- R11: With 0xD1 pending, a data write is absorbed: no valid strobe fires and the mode register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_byte | input | 8 | Command byte |
| data_wr | input | 1 | Data-port write strobe |
| data_byte | input | 8 | Data byte |
| kbd_rx_valid | output | 1 | Keyboard reply stream byte valid |
| kbd_rx_byte | output | 8 | Keyboard reply stream byte |
| aux_rx_valid | output | 1 | Aux reply stream byte valid |
| aux_rx_byte | output | 8 | Aux reply stream byte |
| kbd_dev_valid | output | 1 | Byte for keyboard device valid |
| kbd_dev_byte | output | 8 | Byte for keyboard device |
| mouse_dev_valid | output | 1 | Byte for mouse device valid |
| mouse_dev_byte | output | 8 | Byte for mouse device |
| mode_out | output | 8 | Mode register |
| status_out | output | 8 | Status register |
| xlate_en | output | 1 | Scan-code translation enable |
| kbd_irq_en | output | 1 | Keyboard interrupt allowed |
| aux_irq_en | output | 1 | Mouse interrupt allowed |
| bad_cmd | output | 1 | One-cycle unknown-command strobe |

## Verification
The bench sweeps all 256 command codes from a fresh reset. For each code it checks the error strobe, the reply, the mode and the status. It then sends two data bytes to show where the first went and that the second falls back to the keyboard device. A decoder with a missing or extra code shows up as a wrong bad_cmd or a missing reply. A pending state that survives its data write would misroute the second byte. Directed cases cover the remaining corners. A non-arming or unknown command issued while a command is pending must not clear it. A second arming command must replace the first. A write on both ports at once must drop the data. A design that mishandled any of these would send the byte to the wrong channel or change the mode when it should not.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // command codes
    localparam byte_t CMD_RD_MODE  = 8'h20;
    localparam byte_t CMD_WR_MODE  = 8'h60;
    localparam byte_t CMD_AUX_OFF  = 8'hA7;
    localparam byte_t CMD_AUX_ON   = 8'hA8;
    localparam byte_t CMD_AUX_TEST = 8'hA9;
    localparam byte_t CMD_SELFTEST = 8'hAA;
    localparam byte_t CMD_KBD_TEST = 8'hAB;
    localparam byte_t CMD_KBD_OFF  = 8'hAD;
    localparam byte_t CMD_KBD_ON   = 8'hAE;
    localparam byte_t CMD_RD_INPUT = 8'hC0;
    localparam byte_t CMD_WR_OUTP  = 8'hD1;
    localparam byte_t CMD_WR_KOBUF = 8'hD2;
    localparam byte_t CMD_WR_AOBUF = 8'hD3;
    localparam byte_t CMD_WR_AUX   = 8'hD4;

    // fixed reply values
    localparam byte_t RPL_SELFTEST = 8'h55;
    localparam byte_t RPL_IF_OK    = 8'h00;
    localparam byte_t RPL_INPUT    = 8'h80;

    // mode register bit positions
    localparam int MB_KIRQ  = 0;
    localparam int MB_AIRQ  = 1;
    localparam int MB_KOFF  = 4;
    localparam int MB_AOFF  = 5;
    localparam int MB_XLATE = 6;

    // status register bit positions
    localparam int SB_SELFTEST = 2;
    localparam int SB_CMD      = 3;
    localparam int SB_UNLOCK   = 4;

    localparam byte_t MODE_RST   = byte_t'((1 << MB_KIRQ) | (1 << MB_AIRQ));
    localparam byte_t STATUS_RST = byte_t'((1 << SB_CMD) | (1 << SB_UNLOCK));

    typedef enum logic [2:0] {
        ACT_BAD,
        ACT_REPLY_MODE,
        ACT_REPLY_CONST,
        ACT_SELFTEST,
        ACT_SET_BIT,
        ACT_CLR_BIT,
        ACT_ARM
    } cmd_act_e;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_MODE,
        PEND_OUTP,
        PEND_KOBUF,
        PEND_AOBUF,
        PEND_AUX
    } pend_e;

    typedef enum logic [2:0] {
        RT_KBD_DEV,
        RT_MODE,
        RT_DROP,
        RT_KQUEUE,
        RT_AQUEUE,
        RT_MOUSE_DEV
    } route_e;

    typedef struct packed {
        cmd_act_e             act;
        byte_t                reply;
        logic [BIT_IDX_W-1:0] bit_idx;
        pend_e                pend;
    } cmd_dec_t;

    function automatic pend_e arm_target(byte_t c);
        case (c)
            CMD_WR_MODE:  return PEND_MODE;
            CMD_WR_OUTP:  return PEND_OUTP;
            CMD_WR_KOBUF: return PEND_KOBUF;
            CMD_WR_AOBUF: return PEND_AOBUF;
            CMD_WR_AUX:   return PEND_AUX;
            default:      return PEND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t    cmd,
    output cmd_dec_t dec
);
    always_comb begin
        dec.act     = ACT_BAD;
        dec.reply   = '0;
        dec.bit_idx = '0;
        dec.pend    = arm_target(cmd);
        case (cmd)
            CMD_RD_MODE:  dec.act = ACT_REPLY_MODE;
            CMD_SELFTEST: begin
                dec.act   = ACT_SELFTEST;
                dec.reply = RPL_SELFTEST;
            end
            CMD_AUX_TEST, CMD_KBD_TEST: begin
                dec.act   = ACT_REPLY_CONST;
                dec.reply = RPL_IF_OK;
            end
            CMD_RD_INPUT: begin
                dec.act   = ACT_REPLY_CONST;
                dec.reply = RPL_INPUT;
            end
            CMD_AUX_OFF: begin
                dec.act     = ACT_SET_BIT;
                dec.bit_idx = BIT_IDX_W'(MB_AOFF);
            end
            CMD_AUX_ON: begin
                dec.act     = ACT_CLR_BIT;
                dec.bit_idx = BIT_IDX_W'(MB_AOFF);
            end
            CMD_KBD_OFF: begin
                dec.act     = ACT_SET_BIT;
                dec.bit_idx = BIT_IDX_W'(MB_KOFF);
            end
            CMD_KBD_ON: begin
                dec.act     = ACT_CLR_BIT;
                dec.bit_idx = BIT_IDX_W'(MB_KOFF);
            end
            CMD_WR_MODE, CMD_WR_OUTP, CMD_WR_KOBUF,
            CMD_WR_AOBUF, CMD_WR_AUX: dec.act = ACT_ARM;
            default: dec.act = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
    import kbc_pkg::*;
(
    input  pend_e  pend,
    output route_e route
);
    always_comb begin
        case (pend)
            PEND_NONE:  route = RT_KBD_DEV;
            PEND_MODE:  route = RT_MODE;
            PEND_OUTP:  route = RT_DROP;
            PEND_KOBUF: route = RT_KQUEUE;
            PEND_AOBUF: route = RT_AQUEUE;
            PEND_AUX:   route = RT_MOUSE_DEV;
            default:    route = RT_DROP;
        endcase
    end
endmodule

// File: rtl/kbc_state.sv
module kbc_state
    import kbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_fire,
    input  cmd_dec_t dec,
    input  logic     data_fire,
    input  byte_t    data_byte,
    input  route_e   route,
    output pend_e    pend,
    output byte_t    mode,
    output byte_t    status,
    output logic     krx_v,
    output byte_t    krx_b,
    output logic     arx_v,
    output byte_t    arx_b,
    output logic     kdev_v,
    output byte_t    kdev_b,
    output logic     mdev_v,
    output byte_t    mdev_b,
    output logic     bad
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_RST;
            status <= STATUS_RST;
            pend   <= PEND_NONE;
            krx_v  <= 1'b0;
            krx_b  <= '0;
            arx_v  <= 1'b0;
            arx_b  <= '0;
            kdev_v <= 1'b0;
            kdev_b <= '0;
            mdev_v <= 1'b0;
            mdev_b <= '0;
            bad    <= 1'b0;
        end else begin
            krx_v  <= 1'b0;
            arx_v  <= 1'b0;
            kdev_v <= 1'b0;
            mdev_v <= 1'b0;
            bad    <= 1'b0;
            if (cmd_fire) begin
                status[SB_CMD] <= 1'b1;
                case (dec.act)
                    ACT_REPLY_MODE: begin
                        krx_v <= 1'b1;
                        krx_b <= mode;
                    end
                    ACT_REPLY_CONST: begin
                        krx_v <= 1'b1;
                        krx_b <= dec.reply;
                    end
                    ACT_SELFTEST: begin
                        status[SB_SELFTEST] <= 1'b1;
                        krx_v <= 1'b1;
                        krx_b <= dec.reply;
                    end
                    ACT_SET_BIT: mode[dec.bit_idx] <= 1'b1;
                    ACT_CLR_BIT: mode[dec.bit_idx] <= 1'b0;
                    ACT_ARM:     pend <= dec.pend;
                    default:     bad <= 1'b1;
                endcase
            end else if (data_fire) begin
                status[SB_CMD] <= 1'b0;
                pend <= PEND_NONE;
                case (route)
                    RT_KBD_DEV: begin
                        kdev_v <= 1'b1;
                        kdev_b <= data_byte;
                    end
                    RT_MODE: mode <= data_byte;
                    RT_KQUEUE: begin
                        krx_v <= 1'b1;
                        krx_b <= data_byte;
                    end
                    RT_AQUEUE: begin
                        arx_v <= 1'b1;
                        arx_b <= data_byte;
                    end
                    RT_MOUSE_DEV: begin
                        mdev_v <= 1'b1;
                        mdev_b <= data_byte;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/kbc_host_engine.sv
module kbc_host_engine
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    input  logic       data_wr,
    input  logic [7:0] data_byte,
    output logic       kbd_rx_valid,
    output logic [7:0] kbd_rx_byte,
    output logic       aux_rx_valid,
    output logic [7:0] aux_rx_byte,
    output logic       kbd_dev_valid,
    output logic [7:0] kbd_dev_byte,
    output logic       mouse_dev_valid,
    output logic [7:0] mouse_dev_byte,
    output logic [7:0] mode_out,
    output logic [7:0] status_out,
    output logic       xlate_en,
    output logic       kbd_irq_en,
    output logic       aux_irq_en,
    output logic       bad_cmd
);
    cmd_dec_t dec;
    pend_e    pend;
    route_e   route;
    byte_t    mode_q;
    byte_t    status_q;
    logic     data_fire;

    // a simultaneous command write wins; the data byte is dropped
    assign data_fire = data_wr & ~cmd_wr;

    kbc_cmd_decode u_dec (
        .cmd (cmd_byte),
        .dec (dec)
    );

    kbc_data_route u_route (
        .pend  (pend),
        .route (route)
    );

    kbc_state u_state (
        .clk       (clk),
        .rst       (rst),
        .cmd_fire  (cmd_wr),
        .dec       (dec),
        .data_fire (data_fire),
        .data_byte (data_byte),
        .route     (route),
        .pend      (pend),
        .mode      (mode_q),
        .status    (status_q),
        .krx_v     (kbd_rx_valid),
        .krx_b     (kbd_rx_byte),
        .arx_v     (aux_rx_valid),
        .arx_b     (aux_rx_byte),
        .kdev_v    (kbd_dev_valid),
        .kdev_b    (kbd_dev_byte),
        .mdev_v    (mouse_dev_valid),
        .mdev_b    (mouse_dev_byte),
        .bad       (bad_cmd)
    );

    assign mode_out   = mode_q;
    assign status_out = status_q;
    assign xlate_en   = mode_q[MB_XLATE];
    assign kbd_irq_en = mode_q[MB_KIRQ] & ~mode_q[MB_KOFF];
    assign aux_irq_en = mode_q[MB_AIRQ];
endmodule

// File: rtl/kbc_host_engine_chk.sv
module kbc_host_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [7:0] cmd_byte,
    input logic       data_wr,
    input logic [7:0] mode_out,
    input logic [7:0] status_out,
    input logic       kbd_rx_valid,
    input logic [7:0] kbd_rx_byte,
    input logic       aux_rx_valid,
    input logic       kbd_dev_valid,
    input logic       mouse_dev_valid,
    input logic       bad_cmd
);
    AST_RESET_VALUES: assert property (@(posedge clk) rst |=> (mode_out == 8'h03 && status_out == 8'h18)); // R1
    AST_CMD_FLAG_SET: assert property (@(posedge clk) disable iff (rst) cmd_wr |=> status_out[3]); // R2
    AST_DATA_FLAG_CLR: assert property (@(posedge clk) disable iff (rst) (data_wr && !cmd_wr) |=> !status_out[3]); // R2
    AST_MODE_REPLY: assert property (@(posedge clk) disable iff (rst) (cmd_wr && cmd_byte == 8'h20) |=> (kbd_rx_valid && kbd_rx_byte == $past(mode_out))); // R3
    AST_SELFTEST_REPLY: assert property (@(posedge clk) disable iff (rst) (cmd_wr && cmd_byte == 8'hAA) |=> (status_out[2] && kbd_rx_valid && kbd_rx_byte == 8'h55)); // R4
    AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (rst) status_out[2] |=> status_out[2]); // R4
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst) $onehot0({kbd_rx_valid, aux_rx_valid, kbd_dev_valid, mouse_dev_valid})); // R7
    AST_BAD_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst) bad_cmd |-> ($stable(mode_out) && !kbd_rx_valid)); // R9
    AST_BOTH_DROPS_DATA: assert property (@(posedge clk) disable iff (rst) (cmd_wr && data_wr) |=> (!kbd_dev_valid && !mouse_dev_valid && !aux_rx_valid)); // R10
endmodule

bind kbc_host_engine kbc_host_engine_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_wr          (cmd_wr),
    .cmd_byte        (cmd_byte),
    .data_wr         (data_wr),
    .mode_out        (mode_out),
    .status_out      (status_out),
    .kbd_rx_valid    (kbd_rx_valid),
    .kbd_rx_byte     (kbd_rx_byte),
    .aux_rx_valid    (aux_rx_valid),
    .kbd_dev_valid   (kbd_dev_valid),
    .mouse_dev_valid (mouse_dev_valid),
    .bad_cmd         (bad_cmd)
);

// File: tb/tb_kbc_host_engine.sv
module tb_kbc_host_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_byte = '0;
    logic       kbd_rx_valid, aux_rx_valid, kbd_dev_valid, mouse_dev_valid;
    logic [7:0] kbd_rx_byte, aux_rx_byte, kbd_dev_byte, mouse_dev_byte;
    logic [7:0] mode_out, status_out;
    logic       xlate_en, kbd_irq_en, aux_irq_en, bad_cmd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    kbc_host_engine dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] c);
        @(negedge clk) begin cmd_wr = 1'b1; cmd_byte = c; end
        @(negedge clk) cmd_wr = 1'b0;
    endtask

    task automatic do_data(input logic [7:0] d);
        @(negedge clk) begin data_wr = 1'b1; data_byte = d; end
        @(negedge clk) data_wr = 1'b0;
    endtask

    function automatic bit is_known(input logic [7:0] c);
        case (c)
            8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB,
            8'hAD, 8'hAE, 8'hC0, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit has_reply(input logic [7:0] c);
        return (c == 8'h20 || c == 8'hA9 || c == 8'hAA || c == 8'hAB || c == 8'hC0);
    endfunction

    function automatic logic [7:0] reply_of(input logic [7:0] c);
        case (c)
            8'h20:   return 8'h03;
            8'hAA:   return 8'h55;
            8'hC0:   return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                done = 1'b1;
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] exp_mode;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(mode_out == 8'h03, "R1 mode", mode_out, 8'h03);
        chk(status_out == 8'h18, "R1 status", status_out, 8'h18);
        chk(!kbd_rx_valid && !aux_rx_valid && !kbd_dev_valid && !mouse_dev_valid && !bad_cmd,
            "R1 strobes", {kbd_rx_valid, aux_rx_valid, kbd_dev_valid, mouse_dev_valid, bad_cmd}, 0);
        chk(kbd_irq_en && aux_irq_en && !xlate_en, "R1 enables", {kbd_irq_en, aux_irq_en, xlate_en}, 3'b110);

        // Sweep of all command codes (R2..R9, R11)
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            cb = 8'(c);
            do_reset();
            do_cmd(cb);
            chk(bad_cmd == !is_known(cb), "R9 bad_cmd", bad_cmd, !is_known(cb));
            chk(kbd_rx_valid == has_reply(cb), "R4 reply valid", kbd_rx_valid, has_reply(cb));
            if (has_reply(cb))
                chk(kbd_rx_byte == reply_of(cb), "R3 R4 reply byte", kbd_rx_byte, reply_of(cb));
            chk(status_out[3], "R2 cmd flag", status_out, 8'h08);
            chk(status_out[2] == (cb == 8'hAA), "R4 selftest bit", status_out[2], cb == 8'hAA);
            exp_mode = (cb == 8'hA7) ? 8'h23 : (cb == 8'hAD) ? 8'h13 : 8'h03;
            chk(mode_out == exp_mode, "R5 R9 mode after cmd", mode_out, exp_mode);
            if (cb == 8'hAD) chk(!kbd_irq_en, "R5 kbd irq off", kbd_irq_en, 0);
            do_data(8'h45);
            chk(!status_out[3], "R2 data flag", status_out, 8'h10);
            case (cb)
                8'h60: begin
                    chk(mode_out == 8'h45, "R8 mode load", mode_out, 8'h45);
                    chk(xlate_en && kbd_irq_en && !aux_irq_en, "R8 R5 derived", {xlate_en, kbd_irq_en, aux_irq_en}, 3'b110);
                end
                8'hD1: chk(!kbd_rx_valid && !aux_rx_valid && !kbd_dev_valid && !mouse_dev_valid && mode_out == 8'h03,
                           "R11 absorbed", {kbd_rx_valid, aux_rx_valid, kbd_dev_valid, mouse_dev_valid}, 0);
                8'hD2: chk(kbd_rx_valid && kbd_rx_byte == 8'h45 && !kbd_dev_valid, "R7 kbd queue", kbd_rx_byte, 8'h45);
                8'hD3: chk(aux_rx_valid && aux_rx_byte == 8'h45 && !kbd_rx_valid, "R7 aux queue", aux_rx_byte, 8'h45);
                8'hD4: chk(mouse_dev_valid && mouse_dev_byte == 8'h45 && !kbd_dev_valid, "R7 mouse", mouse_dev_byte, 8'h45);
                default: chk(kbd_dev_valid && kbd_dev_byte == 8'h45, "R7 kbd dev", kbd_dev_byte, 8'h45);
            endcase
            do_data(8'h12);
            chk(kbd_dev_valid && kbd_dev_byte == 8'h12 && !mouse_dev_valid && !aux_rx_valid && !kbd_rx_valid,
                "R7 pending cleared", kbd_dev_byte, 8'h12);
        end

        // R5 clear commands
        do_reset();
        do_cmd(8'hA7); do_cmd(8'hA8);
        chk(mode_out == 8'h03, "R5 aux on", mode_out, 8'h03);
        do_cmd(8'hAD); do_cmd(8'hAE);
        chk(mode_out == 8'h03 && kbd_irq_en, "R5 kbd on", mode_out, 8'h03);

        // R3 reply reflects a written mode
        do_cmd(8'h60); do_data(8'hC3);
        do_cmd(8'h20);
        chk(kbd_rx_valid && kbd_rx_byte == 8'hC3, "R3 mode readback", kbd_rx_byte, 8'hC3);

        // R6 non-arming command keeps pending; R4 sticky selftest
        do_reset();
        do_cmd(8'hD3); do_cmd(8'hAA); do_cmd(8'hA7);
        do_data(8'h9E);
        chk(aux_rx_valid && aux_rx_byte == 8'h9E, "R6 pending kept", aux_rx_byte, 8'h9E);
        chk(status_out[2], "R4 sticky", status_out, 8'h14);

        // R6 arming replaces
        do_cmd(8'hD2); do_cmd(8'hD4);
        do_data(8'h77);
        chk(mouse_dev_valid && mouse_dev_byte == 8'h77 && !kbd_rx_valid, "R6 replace", mouse_dev_byte, 8'h77);

        // R9 unknown command keeps pending
        do_cmd(8'hD2); do_cmd(8'hFF);
        chk(bad_cmd && status_out[3], "R9 strobe", bad_cmd, 1);
        do_data(8'h31);
        chk(kbd_rx_valid && kbd_rx_byte == 8'h31, "R9 pending kept", kbd_rx_byte, 8'h31);
        chk(!bad_cmd, "R9 one cycle", bad_cmd, 0);

        // R10 simultaneous writes
        do_reset();
        @(negedge clk) begin cmd_wr = 1'b1; cmd_byte = 8'hA7; data_wr = 1'b1; data_byte = 8'h66; end
        @(negedge clk) begin cmd_wr = 1'b0; data_wr = 1'b0; end
        chk(!kbd_dev_valid && mode_out == 8'h23 && status_out[3], "R10 data dropped", {kbd_dev_valid, mode_out}, 9'h023);
        do_cmd(8'hD4);
        @(negedge clk) begin cmd_wr = 1'b1; cmd_byte = 8'hA8; data_wr = 1'b1; data_byte = 8'h44; end
        @(negedge clk) begin cmd_wr = 1'b0; data_wr = 1'b0; end
        chk(!mouse_dev_valid && mode_out == 8'h03, "R10 pending survives", mouse_dev_valid, 0);
        do_data(8'h44);
        chk(mouse_dev_valid && mouse_dev_byte == 8'h44, "R10 later data routed", mouse_dev_byte, 8'h44);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule